// File: doc/BRIEF.md
# Source Address Learning Controller

This block sits beside a network receiver and an external address CAM. At the start of every received frame it launches the CAM compare routine, which looks up both the destination and the source address. It then collects the lookup result for the source address and, once the frame status error indicator has arrived, decides whether that source address is new and should be added to the address database. When it decides to learn, it starts the CAM learn routine and pushes the address into the address FIFO.

The decision combines several conditions. The source address must have missed in the CAM. The frame must be error-free, unless errored frames are accepted by configuration. The routing information indicator of the frame must be zero, unless transparent-bridging-only mode is set. The frame type must be enabled in a per-type mask. A frame is learned at most once. A new start delimiter that arrives while a compare is still pending aborts that compare.

Top module: `sa_learn_ctrl`

## Requirements
- R1: One cycle after `sd_seen` is sampled high, `cmp_start` is high for exactly one cycle.
- R2: `cmp_abort` pulses together with `cmp_start` when `sd_seen` arrives while the previous compare has not yet returned a result (no `lkup_valid` since the last start). Otherwise `cmp_abort` stays low.
- R3: `sa_match` goes high one cycle after an accepted lookup with `sa_hit` = 1 and is cleared one cycle after `sd_seen`. A `lkup_valid` that arrives while no compare is pending is ignored.
- R4: For an enabled, error-free frame whose source address missed, `learn_start` pulses one cycle after `ei_seen`.
- R5: If `frame_err` = 1 with `ei_seen`, no learn occurs unless `cfg_accept_err` = 1.
- R6: If the frame's `rii` (captured with `sd_seen`) is 1, no learn occurs unless `cfg_transparent` = 1.
- R7: Learning requires `cfg_learn_en[frame_type]` = 1, where `frame_type` is captured with `sd_seen` and bit i of the mask enables type i.
- R8: At most one `learn_start` occurs per frame. A later `ei_seen` in the same frame has no effect.
- R9: `fifo_push` pulses in the same cycle as `learn_start`, with `fifo_data` holding the looked-up source address, unless `fifo_full` was high together with `ei_seen`. In that case `learn_start` still pulses but no push occurs.
- R10: An `ei_seen` that arrives before the lookup result for the frame causes no learn.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_seen | input | 1 | Start delimiter strobe |
| frame_type | input | FT_W | Frame type, sampled with sd_seen |
| rii | input | 1 | Routing information indicator, sampled with sd_seen |
| lkup_valid | input | 1 | CAM lookup result strobe |
| da_hit | input | 1 | Destination address found (informational) |
| sa_hit | input | 1 | Source address found |
| sa_addr | input | ADDR_W | Source address of the frame |
| ei_seen | input | 1 | Frame status error indicator strobe |
| frame_err | input | 1 | Frame in error, valid with ei_seen |
| fifo_full | input | 1 | Address FIFO full |
| cfg_learn_en | input | 2**FT_W | Per-frame-type learn enable mask |
| cfg_accept_err | input | 1 | Allow learning from errored frames |
| cfg_transparent | input | 1 | Transparent-bridging-only: ignore rii |
| cmp_start | output | 1 | Compare routine start pulse |
| cmp_abort | output | 1 | Abort of a pending compare |
| sa_match | output | 1 | Source address found in CAM |
| learn_start | output | 1 | Learn routine start pulse |
| fifo_push | output | 1 | Push request to address FIFO |
| fifo_data | output | ADDR_W | Address to push |

## Verification
The learn decision is tried with frames that differ in exactly one gating condition from a baseline that learns: a hit, an error with and without acceptance, a set indicator with and without transparent mode, an enabled and a masked frame type, and a full FIFO. Each of these shows whether that single term enters the decision. Ordering cases are also covered: a repeated error indicator, an error indicator ahead of the lookup result, a stray lookup strobe, and back-to-back start delimiters. These tell apart per-frame state that is cleared correctly from state that leaks between frames.

// File: rtl/sa_learn_ctrl.sv
module sa_learn_ctrl #(
  parameter int ADDR_W = 48,
  parameter int FT_W   = 3,
  localparam int NTYPES = 1 << FT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_seen,
  input  logic [FT_W-1:0]   frame_type,
  input  logic              rii,
  input  logic              lkup_valid,
  input  logic              da_hit,
  input  logic              sa_hit,
  input  logic [ADDR_W-1:0] sa_addr,
  input  logic              ei_seen,
  input  logic              frame_err,
  input  logic              fifo_full,
  input  logic [NTYPES-1:0] cfg_learn_en,
  input  logic              cfg_accept_err,
  input  logic              cfg_transparent,
  output logic              cmp_start,
  output logic              cmp_abort,
  output logic              sa_match,
  output logic              learn_start,
  output logic              fifo_push,
  output logic [ADDR_W-1:0] fifo_data
);

  logic              cmp_pend, have_res, hit_q, learned, rii_q;
  logic [FT_W-1:0]   ft_q;
  logic [ADDR_W-1:0] addr_q;
  logic              da_hit_unused;

  assign da_hit_unused = da_hit;

  wire err_ok   = !frame_err || cfg_accept_err;
  wire route_ok = !rii_q || cfg_transparent;
  wire learn_go = ei_seen && !sd_seen && have_res && !hit_q && !learned &&
                  err_ok && route_ok && cfg_learn_en[ft_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_pend    <= 1'b0;
      have_res    <= 1'b0;
      hit_q       <= 1'b0;
      learned     <= 1'b0;
      rii_q       <= 1'b0;
      ft_q        <= '0;
      addr_q      <= '0;
      cmp_start   <= 1'b0;
      cmp_abort   <= 1'b0;
      sa_match    <= 1'b0;
      learn_start <= 1'b0;
      fifo_push   <= 1'b0;
      fifo_data   <= '0;
    end else begin
      cmp_start   <= sd_seen;
      cmp_abort   <= sd_seen && cmp_pend;
      learn_start <= learn_go;
      fifo_push   <= learn_go && !fifo_full;
      if (learn_go && !fifo_full) fifo_data <= addr_q;
      if (sd_seen) begin
        cmp_pend <= 1'b1;
        have_res <= 1'b0;
        hit_q    <= 1'b0;
        learned  <= 1'b0;
        sa_match <= 1'b0;
        ft_q     <= frame_type;
        rii_q    <= rii;
      end else begin
        if (lkup_valid && cmp_pend) begin
          cmp_pend <= 1'b0;
          have_res <= 1'b1;
          hit_q    <= sa_hit;
          sa_match <= sa_hit;
          addr_q   <= sa_addr;
        end
        if (learn_go) learned <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sa_learn_ctrl_chk.sv
module sa_learn_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sd_seen,
  input logic ei_seen,
  input logic fifo_full,
  input logic cmp_start,
  input logic cmp_abort,
  input logic sa_match,
  input logic learn_start,
  input logic fifo_push
);

  a_r1_start_follows_sd: assert property (@(posedge clk) disable iff (!rst_n)
    sd_seen |=> cmp_start);

  a_r1_start_needs_sd: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_start |-> $past(sd_seen));

  a_r2_abort_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_abort |-> cmp_start);

  a_r3_match_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    sd_seen |=> !sa_match);

  a_r4_learn_after_ei: assert property (@(posedge clk) disable iff (!rst_n)
    learn_start |-> $past(ei_seen));

  a_r8_single_learn: assert property (@(posedge clk) disable iff (!rst_n)
    learn_start |=> !learn_start);

  a_r9_push_needs_learn: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> learn_start);

  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !$past(fifo_full));

endmodule

bind sa_learn_ctrl sa_learn_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sd_seen(sd_seen), .ei_seen(ei_seen),
  .fifo_full(fifo_full), .cmp_start(cmp_start), .cmp_abort(cmp_abort),
  .sa_match(sa_match), .learn_start(learn_start), .fifo_push(fifo_push)
);

// File: tb/test_sa_learn_ctrl.sv
`timescale 1ns/1ps
module test_sa_learn_ctrl;
  localparam int AW = 48;
  localparam int FW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sd_seen = 0, rii = 0, lkup_valid = 0, da_hit = 0, sa_hit = 0;
  logic ei_seen = 0, frame_err = 0, fifo_full = 0;
  logic cfg_accept_err = 0, cfg_transparent = 0;
  logic [FW-1:0] frame_type = '0;
  logic [AW-1:0] sa_addr = '0;
  logic [7:0] cfg_learn_en = 8'hFF;
  logic cmp_start, cmp_abort, sa_match, learn_start, fifo_push;
  logic [AW-1:0] fifo_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sa_learn_ctrl #(.ADDR_W(AW), .FT_W(FW)) i_sa_learn_ctrl (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start_frame(input logic [FW-1:0] ft, input logic ri);
    sd_seen = 1; frame_type = ft; rii = ri;
    step();
    sd_seen = 0;
    chk("R1 cmp_start", cmp_start, 1);
    step();
    chk("R1 cmp_start single", cmp_start, 0);
  endtask

  task automatic lookup(input logic hit, input logic [AW-1:0] a);
    lkup_valid = 1; sa_hit = hit; sa_addr = a; da_hit = 1;
    step();
    lkup_valid = 0; sa_hit = 0; da_hit = 0;
    chk("R3 sa_match", sa_match, hit);
  endtask

  task automatic end_frame(input logic err, input logic full, input logic exp_learn,
                           input logic [AW-1:0] a, input string req);
    ei_seen = 1; frame_err = err; fifo_full = full;
    step();
    ei_seen = 0; frame_err = 0; fifo_full = 0;
    chk(req, learn_start, exp_learn);
    chk("R9 push", fifo_push, exp_learn & !full);
    if (exp_learn && !full) chk("R9 data", fifo_data, a);
    step();
    chk("R8 learn pulse ends", learn_start, 0);
  endtask

  task automatic frame(input logic [FW-1:0] ft, input logic ri, input logic hit,
                       input logic err, input logic full, input logic exp_learn,
                       input logic [AW-1:0] a, input string req);
    start_frame(ft, ri);
    lookup(hit, a);
    end_frame(err, full, exp_learn, a, req);
  endtask

  task automatic t_reset();
    chk("R11 cmp_start", cmp_start, 0);
    chk("R11 cmp_abort", cmp_abort, 0);
    chk("R11 sa_match", sa_match, 0);
    chk("R11 learn_start", learn_start, 0);
    chk("R11 fifo_push", fifo_push, 0);
  endtask

  task automatic t_basic();
    frame(3'd2, 0, 0, 0, 0, 1, 48'h0A0B0C0D0E0F, "R4 basic learn");
    frame(3'd6, 0, 0, 0, 0, 1, 48'h123456789ABC, "R4 second address");
  endtask

  task automatic t_hit();
    frame(3'd2, 0, 1, 0, 0, 0, 48'h111111111111, "R3 hit no learn");
  endtask

  task automatic t_err();
    frame(3'd1, 0, 0, 1, 0, 0, 48'h222222222222, "R5 errored blocked");
    cfg_accept_err = 1;
    frame(3'd1, 0, 0, 1, 0, 1, 48'h333333333333, "R5 errored accepted");
    cfg_accept_err = 0;
  endtask

  task automatic t_rii();
    frame(3'd1, 1, 0, 0, 0, 0, 48'h444444444444, "R6 rii blocks");
    cfg_transparent = 1;
    frame(3'd1, 1, 0, 0, 0, 1, 48'h555555555555, "R6 transparent");
    cfg_transparent = 0;
  endtask

  task automatic t_mask();
    cfg_learn_en = 8'b0000_0100;
    frame(3'd2, 0, 0, 0, 0, 1, 48'h666666666666, "R7 enabled type");
    frame(3'd5, 0, 0, 0, 0, 0, 48'h777777777777, "R7 masked type");
    cfg_learn_en = 8'hFF;
  endtask

  task automatic t_full();
    frame(3'd0, 0, 0, 0, 1, 1, 48'h888888888888, "R9 full still learns");
  endtask

  task automatic t_double_ei();
    frame(3'd3, 0, 0, 0, 0, 1, 48'h999999999999, "R8 first ei");
    end_frame(0, 0, 0, 48'h0, "R8 second ei ignored");
  endtask

  task automatic t_abort();
    sd_seen = 1; step(); sd_seen = 0;
    chk("R2 no abort when idle", cmp_abort, 0);
    step();
    sd_seen = 1; step(); sd_seen = 0;
    chk("R2 abort pending", cmp_abort, 1);
    chk("R1 restart", cmp_start, 1);
    step();
    chk("R2 abort pulse ends", cmp_abort, 0);
    lookup(0, 48'h0);
    sd_seen = 1; step(); sd_seen = 0;
    chk("R2 no abort after result", cmp_abort, 0);
    step();
  endtask

  task automatic t_early_ei();
    start_frame(3'd4, 0);
    end_frame(0, 0, 0, 48'h0, "R10 ei before lookup");
  endtask

  task automatic t_stray();
    start_frame(3'd4, 0);
    lookup(0, 48'hABCDABCDABCD);
    lkup_valid = 1; sa_hit = 1; step(); lkup_valid = 0; sa_hit = 0;
    chk("R3 stray lookup ignored", sa_match, 0);
    end_frame(0, 0, 1, 48'hABCDABCDABCD, "R3 stray kept miss");
    start_frame(3'd4, 0);
    lookup(1, 48'h1);
    sd_seen = 1; step(); sd_seen = 0;
    chk("R3 cleared by sd", sa_match, 0);
    step();
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1;
    step();
    t_basic();
    t_hit();
    t_err();
    t_rii();
    t_mask();
    t_full();
    t_double_ei();
    t_abort();
    t_early_ei();
    t_stray();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule